// File: doc/BRIEF.md
# Network Media Port Auto-Selector

This block decides which of three network media ports carries traffic: the media-independent PHY port (MII), the 10 Mb/s twisted-pair port (TP) or the attachment-unit fallback port (AUI). It works in one of two modes, set by an auto-select bit that the block holds itself.

In automatic mode the choice follows a fixed priority. A present PHY wins. If there is no PHY, the twisted-pair port is used when it is in link pass. Otherwise the attachment-unit port is used. In manual mode the choice comes from a 2-bit software port field.

The chosen port is registered and shown both as a one-hot select and as a 2-bit status code. A change of port is held back while a frame is being sent. The block also produces the enable for twisted-pair link beat pulses.

Top module: `media_port_select`

## Requirements
- R1: While `hardRstN` is low, `autoSel` reads 1, `portOneHot` is 3'b001 (AUI) and `portStatus` is 2'b00.
- R2: With `autoSel`=1 and `phyPresent`=1, the next evaluation selects MII: `portOneHot`=3'b100 and `portStatus`=2'b11.
- R3: With `autoSel`=1, `phyPresent`=0 and either `linkPass` or `linkTestOvr` high, the next evaluation selects TP: `portOneHot`=3'b010 and `portStatus`=2'b01.
- R4: With `autoSel`=1, `phyPresent`=0, `linkPass`=0 and `linkTestOvr`=0, the next evaluation selects AUI: `portOneHot`=3'b001 and `portStatus`=2'b00.
- R5: With `autoSel`=0, the selection follows `portSelSw`. Code 00 selects AUI, 01 selects TP and 11 selects MII. Code 10 keeps the previous selection.
- R6: While `txBusy`=1, and neither `softRst` nor `stopCmd` is high, the selection does not change. A pending change takes effect at the first clock edge at which `txBusy` is 0.
- R7: `beatEnable` equals NOT `phyPresent` when `autoSel`=1. It equals 1 exactly when `portSelSw`=01 when `autoSel`=0.
- R8: `softRst` and `stopCmd` leave `autoSel` unchanged. Either of them lets the selection update at that edge even while `txBusy`=1.
- R9: A pulse on `autoWrEn` loads `autoWrVal` into `autoSel` at that clock edge. Selection uses the new mode from the following edge on.
- R10: `portOneHot` always has exactly one bit set, and it agrees with `portStatus`: bit0 AUI (00), bit1 TP (01), bit2 MII (11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Soft reset pulse; aborts any transmit hold |
| stopCmd | input | 1 | Stop command pulse; aborts any transmit hold |
| autoWrEn | input | 1 | Write strobe for the auto-select bit |
| autoWrVal | input | 1 | Value written to the auto-select bit |
| phyPresent | input | 1 | External PHY detected |
| linkPass | input | 1 | Twisted-pair link integrity in pass state |
| linkTestOvr | input | 1 | Forces twisted-pair link pass |
| portSelSw | input | 2 | Software port field used in manual mode |
| txBusy | input | 1 | A frame transmission is in progress |
| portOneHot | output | 3 | Registered one-hot port select {MII, TP, AUI} |
| portStatus | output | 2 | Code of the selected port, for readback |
| beatEnable | output | 1 | Enable for twisted-pair link beat pulses |
| autoSel | output | 1 | Current auto-select bit |

## Verification
The bench sweeps every combination of mode, PHY presence, link pass, override, port code and transmit flag, so each priority corner is covered. If the priority order were wrong, a present PHY would lose to a good twisted-pair link. If the override were ignored, a link-fail port with the override set would fall back to AUI. The reserved code 10 is applied after a known selection; a design that decoded it as a port would move. Transmit-hold and abort corners cover several cases: a design that switched mid-frame would change `portStatus` while `txBusy` is high, and one that ignored soft reset or stop would keep a stale port. A design whose soft reset cleared the mode bit would read `autoSel` as 0.

// File: rtl/media_sel_pkg.sv
package media_sel_pkg;

  localparam int NUM_PORTS = 3;
  localparam int CODE_W    = 2;

  typedef enum logic [CODE_W-1:0] {
    PORT_AUI = 2'b00,
    PORT_TP  = 2'b01,
    PORT_RSV = 2'b10,
    PORT_MII = 2'b11
  } portCode_t;

  typedef struct packed {
    logic      loadSel;
    portCode_t nextCode;
    logic      loadAuto;
    logic      autoVal;
  } selStrobe_t;

  // one-hot bit index -> port code
  function automatic portCode_t codeOfIdx(input int idx);
    case (idx)
      0:       codeOfIdx = PORT_AUI;
      1:       codeOfIdx = PORT_TP;
      default: codeOfIdx = PORT_MII;
    endcase
  endfunction

endpackage

// File: rtl/mps_ctrl.sv
module mps_ctrl
  import media_sel_pkg::*;
(
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              autoSel,
  input  logic              softRst,
  input  logic              stopCmd,
  input  logic              autoWrEn,
  input  logic              autoWrVal,
  input  logic              phyPresent,
  input  logic              linkPass,
  input  logic              linkTestOvr,
  input  logic [CODE_W-1:0] portSelSw,
  input  logic              txBusy,
  output selStrobe_t        strobe,
  output logic              beatEnable
);

  logic      tpLinkUp;
  logic      abortTx;
  portCode_t autoCode;
  portCode_t wantCode;
  logic      wantValid;

  assign tpLinkUp = linkPass | linkTestOvr;
  assign abortTx  = softRst | stopCmd;

  // fixed priority: PHY, then twisted-pair link, then AUI
  always_comb begin
    if (phyPresent)    autoCode = PORT_MII;
    else if (tpLinkUp) autoCode = PORT_TP;
    else               autoCode = PORT_AUI;
  end

  always_comb begin
    if (autoSel) begin
      wantCode  = autoCode;
      wantValid = 1'b1;
    end else begin
      wantCode  = portCode_t'(portSelSw);
      wantValid = (portSelSw != PORT_RSV);
    end
  end

  always_comb begin
    strobe.nextCode = wantCode;
    strobe.loadSel  = wantValid & (~txBusy | abortTx);
    strobe.loadAuto = autoWrEn;
    strobe.autoVal  = autoWrVal;
  end

  always_comb begin
    if (autoSel) beatEnable = ~phyPresent;
    else         beatEnable = (portSelSw == PORT_TP);
  end

  p_reserved_noload_r5: assert property (@(posedge clk) disable iff (!hardRstN)
    (!autoSel && portSelSw == 2'b10) |-> !strobe.loadSel);

  p_phy_wins_r2: assert property (@(posedge clk) disable iff (!hardRstN)
    (autoSel && phyPresent) |-> (strobe.nextCode == PORT_MII));

  p_ovr_link_r3: assert property (@(posedge clk) disable iff (!hardRstN)
    (autoSel && !phyPresent && linkTestOvr) |-> (strobe.nextCode == PORT_TP));

endmodule

// File: rtl/mps_dp.sv
module mps_dp
  import media_sel_pkg::*;
(
  input  logic                 clk,
  input  logic                 hardRstN,
  input  selStrobe_t           strobe,
  output logic                 autoSel,
  output portCode_t            selCode,
  output logic [NUM_PORTS-1:0] portOneHot
);

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)           autoSel <= 1'b1;
    else if (strobe.loadAuto) autoSel <= strobe.autoVal;
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)           selCode <= PORT_AUI;
    else if (strobe.loadSel) selCode <= strobe.nextCode;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_dec
    assign portOneHot[g] = (selCode == codeOfIdx(g));
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!hardRstN)
    $countones(portOneHot) == 1);

  p_hold_r6: assert property (@(posedge clk) disable iff (!hardRstN)
    !strobe.loadSel |=> $stable(selCode));

endmodule

// File: rtl/media_port_select.sv
module media_port_select
  import media_sel_pkg::*;
(
  input  logic                 clk,
  input  logic                 hardRstN,
  input  logic                 softRst,
  input  logic                 stopCmd,
  input  logic                 autoWrEn,
  input  logic                 autoWrVal,
  input  logic                 phyPresent,
  input  logic                 linkPass,
  input  logic                 linkTestOvr,
  input  logic [CODE_W-1:0]    portSelSw,
  input  logic                 txBusy,
  output logic [NUM_PORTS-1:0] portOneHot,
  output logic [CODE_W-1:0]    portStatus,
  output logic                 beatEnable,
  output logic                 autoSel
);

  selStrobe_t strobe;
  portCode_t  selCode;

  mps_ctrl u_ctrl (
    .clk        (clk),
    .hardRstN   (hardRstN),
    .autoSel    (autoSel),
    .softRst    (softRst),
    .stopCmd    (stopCmd),
    .autoWrEn   (autoWrEn),
    .autoWrVal  (autoWrVal),
    .phyPresent (phyPresent),
    .linkPass   (linkPass),
    .linkTestOvr(linkTestOvr),
    .portSelSw  (portSelSw),
    .txBusy     (txBusy),
    .strobe     (strobe),
    .beatEnable (beatEnable)
  );

  mps_dp u_dp (
    .clk       (clk),
    .hardRstN  (hardRstN),
    .strobe    (strobe),
    .autoSel   (autoSel),
    .selCode   (selCode),
    .portOneHot(portOneHot)
  );

  assign portStatus = selCode;

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!hardRstN)
    (txBusy && !softRst && !stopCmd) |=> $stable(portStatus));

  p_auto_kept_r8: assert property (@(posedge clk) disable iff (!hardRstN)
    ((softRst || stopCmd) && !autoWrEn) |=> $stable(autoSel));

  p_beat_auto_r7: assert property (@(posedge clk) disable iff (!hardRstN)
    (autoSel && phyPresent) |-> !beatEnable);

endmodule

// File: tb/media_port_select_bench.sv
module media_port_select_bench;

  logic clk = 1'b0;
  logic hardRstN = 1'b0;
  logic softRst = 0, stopCmd = 0, autoWrEn = 0, autoWrVal = 0;
  logic phyPresent = 0, linkPass = 0, linkTestOvr = 0, txBusy = 0;
  logic [1:0] portSelSw = 2'b00;
  logic [2:0] portOneHot;
  logic [1:0] portStatus;
  logic beatEnable, autoSel;

  int checks = 0;
  int errors = 0;
  logic finished = 0;

  logic       mAuto;
  logic [1:0] mSel;

  always #10 clk = ~clk;

  media_port_select u_media_port_select (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .stopCmd(stopCmd),
    .autoWrEn(autoWrEn), .autoWrVal(autoWrVal), .phyPresent(phyPresent),
    .linkPass(linkPass), .linkTestOvr(linkTestOvr), .portSelSw(portSelSw),
    .txBusy(txBusy), .portOneHot(portOneHot), .portStatus(portStatus),
    .beatEnable(beatEnable), .autoSel(autoSel)
  );

  function automatic logic [2:0] hotOf(input logic [1:0] c);
    case (c)
      2'b00:   hotOf = 3'b001;
      2'b01:   hotOf = 3'b010;
      default: hotOf = 3'b100;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock; reference model advanced from requirements R2-R6, R8, R9
  task automatic tick();
    logic [1:0] want;
    logic       ok;
    logic [1:0] nSel;
    logic       nAuto;
    if (mAuto) begin
      want = phyPresent ? 2'b11 : ((linkPass | linkTestOvr) ? 2'b01 : 2'b00);
      ok = 1'b1;
    end else begin
      want = portSelSw;
      ok = (portSelSw != 2'b10);
    end
    nSel  = (ok && (!txBusy || softRst || stopCmd)) ? want : mSel;
    nAuto = autoWrEn ? autoWrVal : mAuto;
    @(posedge clk);
    @(negedge clk);
    mSel  = nSel;
    mAuto = nAuto;
  endtask

  task automatic checkAll(input string req);
    logic expBeat;
    expBeat = mAuto ? !phyPresent : (portSelSw == 2'b01);
    chk(req, {5'd0, portOneHot}, {5'd0, hotOf(mSel)});
    chk(req, {6'd0, portStatus}, {6'd0, mSel});
    chk("R7", {7'd0, beatEnable}, {7'd0, expBeat});
    chk("R9", {7'd0, autoSel}, {7'd0, mAuto});
    chk("R10", {5'd0, portOneHot}, {5'd0, hotOf(portStatus)});
  endtask

  task automatic writeAuto(input logic v);
    autoWrEn = 1; autoWrVal = v;
    tick();
    autoWrEn = 0;
  endtask

  initial begin
    mAuto = 1'b1;
    mSel  = 2'b00;
    #25;
    // R1: reset state
    chk("R1", {7'd0, autoSel}, 8'd1);
    chk("R1", {5'd0, portOneHot}, 8'd1);
    chk("R1", {6'd0, portStatus}, 8'd0);
    @(negedge clk);
    hardRstN = 1;

    // exhaustive sweep: R2 R3 R4 R5 R6 R7
    for (int a = 0; a < 2; a++)
      for (int v = 0; v < 64; v++) begin
        writeAuto(a[0]);
        phyPresent  = v[0];
        linkPass    = v[1];
        linkTestOvr = v[2];
        portSelSw   = v[4:3];
        txBusy      = v[5];
        tick();
        if (v[5]) checkAll("R6");
        else if (a == 0) checkAll("R5");
        else if (v[0]) checkAll("R2");
        else if (v[1] | v[2]) checkAll("R3");
        else checkAll("R4");
        txBusy = 0;
        tick();
        checkAll(a == 0 ? "R5" : "R6");
      end

    // R5: reserved code keeps the previous port
    writeAuto(1'b0);
    portSelSw = 2'b01; tick();
    portSelSw = 2'b10; tick(); tick();
    chk("R5", {6'd0, portStatus}, 8'd1);

    // R8: soft reset and stop keep mode and abort hold
    portSelSw = 2'b11; txBusy = 1; tick();
    chk("R6", {6'd0, portStatus}, 8'd1);
    softRst = 1; tick(); softRst = 0;
    chk("R8", {6'd0, portStatus}, 8'd3);
    chk("R8", {7'd0, autoSel}, 8'd0);
    portSelSw = 2'b00; tick();
    stopCmd = 1; tick(); stopCmd = 0;
    chk("R8", {6'd0, portStatus}, 8'd0);
    chk("R8", {7'd0, autoSel}, 8'd0);
    txBusy = 0;

    // R9: mode write visible the same edge, used from the next
    phyPresent = 1; portSelSw = 2'b01;
    autoWrEn = 1; autoWrVal = 1; tick(); autoWrEn = 0;
    chk("R9", {7'd0, autoSel}, 8'd1);
    chk("R9", {6'd0, portStatus}, 8'd1);
    tick();
    chk("R9", {6'd0, portStatus}, 8'd3);

    // R1: hard reset mid-run
    writeAuto(1'b0);
    hardRstN = 0; #3;
    chk("R1", {7'd0, autoSel}, 8'd1);
    chk("R1", {6'd0, portStatus}, 8'd0);
    hardRstN = 1;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule